// File: doc/BRIEF.md
# Serial Configuration Port with Read-Back Gated Output

This block is the slave end of a four-wire serial control port that configures a data converter. A host frames each transaction by pulling the active-low enable low and clocking sixteen bits: an address byte, then a data byte, each most significant bit first and sampled on rising serial-clock edges. With read-back off, a complete frame writes the data byte into the addressed register. Address 0 is a control register. It holds a self-clearing soft-reset bit and a read-back bit. Setting the read-back bit alone switches the port into read-back mode. In that mode, the data phase of every frame shifts the addressed register out on the serial output, and writes land only on address 0.

The serial pins are brought into the system clock domain by a short synchronizer chain, and all actions fire on the detected rising edge of the serial clock. The serial output is enabled by the read-back bit and by nothing else. The enable input has no say in it. The port therefore keeps driving its output between frames for as long as read-back is on. The control register itself can never be read back.

The frame controller has four states. IDLE waits for the enable to go low. The transition IDLE to ADDR happens when the enable is seen low. ADDR to DATA happens on the eighth address rising edge, when the read word is captured. DATA to HOLD happens on the eighth data rising edge, when the write is issued. HOLD ignores further clocks. The transition back to IDLE is taken from ADDR, DATA or HOLD whenever the enable is seen high. A frame cut short this way is dropped.

Top module: `serial_cfg_port`

## Requirements
- R1: The serial output changes only in the cycle that follows a detected rising edge of the serial clock. It never changes around a falling edge, so the host can latch it on the falling edge.
- R2: The output enable equals the read-back bit, which is bit 1 of register 0. After reset, the output enable is 0 and the serial output is 0.
- R3: A frame is 16 rising serial-clock edges with the enable low: an 8-bit address, then 8 data bits, both MSB first. With read-back off, the frame writes the data byte into the addressed register. Writes to addresses of NUM_REGS and above change nothing.
- R4: The enable input has no effect on the output enable. With read-back on, the output stays enabled and holds its value while the enable is high.
- R5: Writing 1 to the read-back bit is enough on its own to enable read-back. In read-back mode, the data phase shifts out the addressed register MSB first: bit 7 appears after the 9th rising edge and bit 0 after the 16th. Addresses of NUM_REGS and above read as 0.
- R6: A read of address 0 returns all zeros, whatever register 0 holds.
- R7: While read-back is on, frames to any address other than 0 leave every register unchanged.
- R8: Writing 1 to bit 0 of register 0 restores every register to its default value and clears the read-back bit. Bit 0 itself is never stored. The default of register k (k of 1 or more) is (k·0x11) mod 256. When bit 0 is 1, it takes priority over bit 1 in the same write.
- R9: A frame during which the enable rises before the 16th rising edge writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sen_n | input | 1 | Active-low frame enable from the host |
| sclk | input | 1 | Serial clock from the host |
| sdata | input | 1 | Serial data from the host |
| sdout | output | 1 | Serial read-back data |
| sdout_oe | output | 1 | Output enable for the serial read-back pad |

## Verification
The assertions assume the serial clock, enable and data are each slow enough to be seen by the synchronizer. They also assume that serial data is steady across each rising edge and that the enable does not move in the same system cycle as a serial-clock edge. The stimulus holds each serial-clock phase for several system cycles. It changes data only while the serial clock is low, a few cycles before the rise. It moves the enable only with the serial clock low and quiet. Under these conditions, write gating, output launch and the control effects of register 0 can be stated as simple one-cycle relations.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_HOLD
    } port_state_e;

    localparam int CTRL_RESET_BIT    = 0;
    localparam int CTRL_READBACK_BIT = 1;

    function automatic logic [31:0] reg_default(input int unsigned idx);
        return 32'(idx) * 32'h11;
    endfunction

endpackage

// File: rtl/cfg_pin_sampler.sv
module cfg_pin_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic sen_n,
    input  logic sdata,
    output logic sclk_rise,
    output logic sen_n_s,
    output logic sdata_s
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] sclk_pipe;
    logic [TOP:0] sen_pipe;
    logic [TOP:0] sdata_pipe;
    logic         sclk_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_pipe  <= '0;
            sen_pipe   <= '1;
            sdata_pipe <= '0;
            sclk_last  <= 1'b0;
        end else begin
            sclk_pipe  <= {sclk_pipe[TOP-1:0], sclk};
            sen_pipe   <= {sen_pipe[TOP-1:0], sen_n};
            sdata_pipe <= {sdata_pipe[TOP-1:0], sdata};
            sclk_last  <= sclk_pipe[TOP];
        end
    end

    assign sclk_rise = sclk_pipe[TOP] & ~sclk_last;
    assign sen_n_s   = sen_pipe[TOP];
    assign sdata_s   = sdata_pipe[TOP];

endmodule

// File: rtl/cfg_frame_fsm.sv
module cfg_frame_fsm
    import cfg_port_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sen_n_s,
    input  logic              sdata_s,
    input  logic              readback,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              sdout
);
    localparam int LONGEST = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
    localparam int CNT_W   = $clog2(LONGEST);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    port_state_e       state_q, state_d;
    logic [CNT_W-1:0]  bit_cnt;
    logic [ADDR_W-1:0] addr_sh;
    logic [DATA_W-2:0] data_sh;
    logic [DATA_W-1:0] out_sh;
    logic [ADDR_W-1:0] addr_full;
    logic              step;

    assign addr_full = {addr_sh[ADDR_W-2:0], sdata_s};
    assign rd_addr   = addr_full;
    assign step      = sclk_rise & ~sen_n_s;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (!sen_n_s) state_d = ST_ADDR;
            ST_ADDR: begin
                if (sen_n_s)                         state_d = ST_IDLE;
                else if (step && bit_cnt == ADDR_LAST) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (sen_n_s)                         state_d = ST_IDLE;
                else if (step && bit_cnt == DATA_LAST) state_d = ST_HOLD;
            end
            ST_HOLD: if (sen_n_s) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            addr_sh <= '0;
            data_sh <= '0;
            out_sh  <= '0;
            sdout   <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            unique case (state_q)
                ST_IDLE: bit_cnt <= '0;
                ST_ADDR: if (step) begin
                    addr_sh <= addr_full;
                    sdout   <= 1'b0;
                    if (bit_cnt == ADDR_LAST) begin
                        bit_cnt <= '0;
                        out_sh  <= readback ? rd_data : '0;
                    end else begin
                        bit_cnt <= bit_cnt + CNT_W'(1);
                    end
                end
                ST_DATA: if (step) begin
                    data_sh <= {data_sh[DATA_W-3:0], sdata_s};
                    sdout   <= out_sh[DATA_W-1];
                    out_sh  <= {out_sh[DATA_W-2:0], 1'b0};
                    if (bit_cnt == DATA_LAST) begin
                        bit_cnt <= '0;
                        wr_en   <= !readback || (addr_sh == '0);
                        wr_addr <= addr_sh;
                        wr_data <= {data_sh, sdata_s};
                    end else begin
                        bit_cnt <= bit_cnt + CNT_W'(1);
                    end
                end
                ST_HOLD: ;
                default: ;
            endcase
        end
    end

    AST_LAUNCH_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdout) |-> $past(sclk_rise)); // R1
    AST_NO_WRITE_AFTER_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(!sen_n_s && state_q == ST_DATA)); // R9

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cfg_port_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              readback
);
    logic              ctrl_wr;
    logic              soft_rst;
    logic [DATA_W-1:0] cfg_q [1:NUM_REGS-1];

    assign ctrl_wr  = wr_en && (wr_addr == '0);
    assign soft_rst = ctrl_wr && wr_data[CTRL_RESET_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        readback <= 1'b0;
        else if (soft_rst) readback <= 1'b0;
        else if (ctrl_wr)  readback <= wr_data[CTRL_READBACK_BIT];
    end

    for (genvar k = 1; k < NUM_REGS; k++) begin : g_cfg
        localparam logic [DATA_W-1:0] DEF_VAL = DATA_W'(reg_default(k));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cfg_q[k] <= DEF_VAL;
            else if (soft_rst)
                cfg_q[k] <= DEF_VAL;
            else if (wr_en && wr_addr == ADDR_W'(k))
                cfg_q[k] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int k = 1; k < NUM_REGS; k++) begin
            if (rd_addr == ADDR_W'(k)) rd_data = cfg_q[k];
        end
    end

    AST_READBACK_WRITE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && readback) |-> (wr_addr == '0)); // R7
    AST_READBACK_ONLY_VIA_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(readback) |-> $past(wr_en && wr_addr == '0)); // R4
    AST_RESET_CLEARS_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !readback); // R8

endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int NUM_REGS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sen_n,
    input  logic sclk,
    input  logic sdata,
    output logic sdout,
    output logic sdout_oe
);
    logic              sclk_rise;
    logic              sen_n_s;
    logic              sdata_s;
    logic              readback;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    cfg_pin_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .sen_n     (sen_n),
        .sdata     (sdata),
        .sclk_rise (sclk_rise),
        .sen_n_s   (sen_n_s),
        .sdata_s   (sdata_s)
    );

    cfg_frame_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (sclk_rise),
        .sen_n_s   (sen_n_s),
        .sdata_s   (sdata_s),
        .readback  (readback),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sdout     (sdout)
    );

    cfg_reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .readback (readback)
    );

    assign sdout_oe = readback;

    AST_OE_IGNORES_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sen_n_s) && !wr_en) |=> $stable(sdout_oe)); // R4

endmodule

// File: tb/test_serial_cfg_port.sv
module test_serial_cfg_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sen_n = 1'b1;
    logic sclk = 1'b0;
    logic sdata = 1'b0;
    logic sdout;
    logic sdout_oe;

    int checks = 0;
    int errors = 0;
    int launch_err = 0;
    bit finished = 1'b0;

    serial_cfg_port i_serial_cfg_port (
        .clk(clk), .rst_n(rst_n), .sen_n(sen_n), .sclk(sclk),
        .sdata(sdata), .sdout(sdout), .sdout_oe(sdout_oe)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] dflt(input int a);
        if (a >= 1 && a < 8) return 8'((a * 17) % 256);
        return 8'h00;
    endfunction

    function automatic logic [7:0] wval(input int a);
        return 8'((a * 37 + 11) % 256);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic frame(input logic [7:0] a, input logic [7:0] d, input int nbits,
                         output logic [7:0] rb);
        logic hold;
        rb = 8'h00;
        sen_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdata = (i < 8) ? a[7-i] : d[15-i];
            repeat (2) @(negedge clk);
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            hold = sdout;
            if (i >= 8) rb[15-i] = sdout;
            sclk = 1'b0;
            repeat (3) @(negedge clk);
            if (sdout !== hold) launch_err++;  // R1: no change around the falling edge
        end
        repeat (2) @(negedge clk);
        sen_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        logic [7:0] rb;
        frame(8'(a), d, 16, rb);
    endtask

    task automatic rd(input int a, output logic [7:0] rb);
        frame(8'(a), 8'h02, 16, rb);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=timeout exp=done");
        summary();
    end

    initial begin
        logic [7:0] rb;
        logic       so;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 reset oe", 32'(sdout_oe), 0);
        chk("R2 reset sdout", 32'(sdout), 0);

        // R5: read-back bit alone enables output; sweep defaults
        wr(0, 8'h02);
        chk("R5 oe after readback set", 32'(sdout_oe), 1);
        for (int a = 0; a < 10; a++) begin
            rd(a, rb);
            if (a == 0) chk("R6 read addr0", 32'(rb), 0);
            else        chk("R5 read default", 32'(rb), 32'(dflt(a)));
        end
        rd(255, rb);
        chk("R5 read unmapped", 32'(rb), 0);

        // R4: enable high does not release the output
        so = sdout;
        repeat (40) @(negedge clk);
        chk("R4 oe with enable high", 32'(sdout_oe), 1);
        chk("R4 sdout held", 32'(sdout), 32'(so));

        // R7: writes ignored during read-back
        wr(3, 8'hA5);
        wr(6, 8'h3C);
        rd(3, rb);
        chk("R7 reg3 unchanged", 32'(rb), 32'(dflt(3)));
        rd(6, rb);
        chk("R7 reg6 unchanged", 32'(rb), 32'(dflt(6)));

        // R2: clear read-back
        wr(0, 8'h00);
        chk("R2 oe cleared", 32'(sdout_oe), 0);

        // R3: write sweep, plus unmapped write
        for (int a = 1; a < 8; a++) wr(a, wval(a));
        wr(9, 8'h77);
        wr(0, 8'h02);
        for (int a = 1; a < 8; a++) begin
            rd(a, rb);
            chk("R3 write readback", 32'(rb), 32'(wval(a)));
        end
        rd(9, rb);
        chk("R3 unmapped write ignored", 32'(rb), 0);
        rd(0, rb);
        chk("R6 read addr0 while set", 32'(rb), 0);

        // R9: aborted frames
        wr(0, 8'h00);
        frame(8'd2, 8'h5A, 12, rb);
        frame(8'd0, 8'h02, 15, rb);
        chk("R9 aborted ctrl write", 32'(sdout_oe), 0);
        frame(8'd4, 8'hC3, 5, rb);
        wr(0, 8'h02);
        rd(2, rb);
        chk("R9 reg2 kept", 32'(rb), 32'(wval(2)));
        rd(4, rb);
        chk("R9 reg4 kept", 32'(rb), 32'(wval(4)));

        // R8: soft reset with both bits set, during read-back
        wr(0, 8'h03);
        chk("R8 readback cleared", 32'(sdout_oe), 0);
        wr(5, 8'hEE);
        wr(0, 8'h01);
        chk("R8 reset alone keeps oe off", 32'(sdout_oe), 0);
        wr(0, 8'h02);
        for (int a = 1; a < 8; a++) begin
            rd(a, rb);
            chk("R8 default restored", 32'(rb), 32'(dflt(a)));
        end
        wr(0, 8'h00);
        chk("R2 oe final", 32'(sdout_oe), 0);

        chk("R1 launch stability", 32'(launch_err), 0);
        summary();
    end
endmodule